// File: doc/BRIEF.md
# Edge-Triggered External Event Controller

This block collects up to 32 external event lines and turns them into active-high interrupt levels for a parent interrupt controller. Each line is one of two kinds, fixed when the block is built. A configurable line watches its synchronized input for rising edges, falling edges or both. It records each detected edge in a pending flag, one register for each edge direction, and holds that flag until software clears it. Software can also raise an event on a configurable line by writing a trigger register. A direct line has no edge or pending logic and passes its synchronized input level straight through.

A mask register then gates every line's output, so a line drives its interrupt only while its mask bit is 1. Software uses a flat register port with address, write data, write enable and combinational read data. Two read-only registers report the build-time settings: which lines are configurable, and which lines are reserved for another requester. Every register holds one bit per line.

Top module: `evt_line_ctrl`

## Requirements
- R1: After reset the edge selects, the mask and both pending registers read zero, and every interrupt output is low.
- R2: On a configurable line, an input rise sets its rising pending bit (offset 0x0C) when its bit at 0x00 is set, and an input fall sets its falling pending bit (offset 0x10) when its bit at 0x04 is set. With both select bits set, both edges are caught. With neither set, no edge is caught. The flag is set on the third rising clock edge after the input changes.
- R3: Writing 1 to a bit at 0x0C or 0x10 clears that pending bit on the next clock edge. Writing 0 leaves the bit as it was.
- R4: Writing 1 to a bit at 0x08 sets the rising pending bit of that configurable line on the next clock edge. Offset 0x08 always reads zero.
- R5: The mask at 0x80 enables a line where its bit is 1. A configurable line's output is the OR of its two pending bits, ANDed with its mask bit. The pending bits are not changed by the mask.
- R6: A line whose capability bit is 0 is direct. Its output is its input level ANDed with its mask bit, two clock edges after the input changes. Its pending bits read zero, and software triggers have no effect on it.
- R7: Offset 0x3EC reads the capability word (1 means configurable) and offset 0x14 reads the reserved-line word. Both are fixed by parameters, and writes to them have no effect.
- R8: If a new edge and a write-one-to-clear reach the same pending bit on the same clock edge, the bit ends up set.
- R9: A read from any offset not listed here returns zero, and a write to such an offset changes no register.
- R10: Values written to 0x00, 0x04 and 0x80 read back unchanged on the next cycle. Read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| evt_in | input | 32 | Asynchronous event inputs, one per line |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| wen | input | 1 | Write enable; the write takes effect on the rising clock edge |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_out | output | 32 | Active-high interrupt level for each line |

## Verification
Each result has a fixed latency, counted from the clock edge that first samples the stimulus. A register write, a software trigger or a pending clear shows up one edge later. A direct line's output follows its input after two edges. An edge on a configurable line sets its pending bit on the third edge. The bench changes inputs on falling clock edges and reads results just after a later falling edge, at exactly those counts. Known lines are probed one edge early to confirm the result has not yet appeared. A cycle model in the bench tracks the same edges, so the interrupt outputs are compared on every cycle and the registers on random reads, during a long random phase of event toggles and register writes.

// File: rtl/evt_pkg.sv
package evt_pkg;

  localparam int unsigned EVT_AW = 12;

  typedef logic [EVT_AW-1:0] evt_addr_t;

  localparam evt_addr_t OFS_RISE_SEL  = 12'h000;
  localparam evt_addr_t OFS_FALL_SEL  = 12'h004;
  localparam evt_addr_t OFS_SW_TRIG   = 12'h008;
  localparam evt_addr_t OFS_RISE_PEND = 12'h00C;
  localparam evt_addr_t OFS_FALL_PEND = 12'h010;
  localparam evt_addr_t OFS_RESERVED  = 12'h014;
  localparam evt_addr_t OFS_MASK      = 12'h080;
  localparam evt_addr_t OFS_CAP       = 12'h3EC;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_RISE_SEL,
    SEL_FALL_SEL,
    SEL_SW_TRIG,
    SEL_RISE_PEND,
    SEL_FALL_PEND,
    SEL_RESERVED,
    SEL_MASK,
    SEL_CAP
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input evt_addr_t a);
    reg_sel_e s;
    case (a)
      OFS_RISE_SEL:  s = SEL_RISE_SEL;
      OFS_FALL_SEL:  s = SEL_FALL_SEL;
      OFS_SW_TRIG:   s = SEL_SW_TRIG;
      OFS_RISE_PEND: s = SEL_RISE_PEND;
      OFS_FALL_PEND: s = SEL_FALL_PEND;
      OFS_RESERVED:  s = SEL_RESERVED;
      OFS_MASK:      s = SEL_MASK;
      OFS_CAP:       s = SEL_CAP;
      default:       s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign rst_ni = stg_q[STAGES-1];

endmodule

// File: rtl/evt_in_sync.sv
module evt_in_sync #(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] evt_in,
  output logic [NUM_LINES-1:0] lvl,
  output logic [NUM_LINES-1:0] rise,
  output logic [NUM_LINES-1:0] fall
);

  logic [NUM_LINES-1:0] stg_q [SYNC_STAGES];
  logic [NUM_LINES-1:0] stg_d [SYNC_STAGES];
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] prev_d;

  // Stage 0 takes the raw input; every later stage takes the one before it.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stg_d[s] = evt_in;
    end else begin : g_next
      always_comb stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[s] <= '0;
      end else begin
        stg_q[s] <= stg_d[s];
      end
    end
  end

  always_comb prev_d = stg_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign lvl  = stg_q[SYNC_STAGES-1];
  assign rise = stg_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~stg_q[SYNC_STAGES-1] & prev_q;

endmodule

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import evt_pkg::*;
#(
  parameter int unsigned          NUM_LINES = 32,
  parameter logic [NUM_LINES-1:0] CFG_LINES = '1,
  parameter logic [NUM_LINES-1:0] RSV_LINES = '0
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  evt_addr_t            addr,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic                 wen,
  input  logic [NUM_LINES-1:0] rpend,
  input  logic [NUM_LINES-1:0] fpend,
  output logic [NUM_LINES-1:0] rsel,
  output logic [NUM_LINES-1:0] fsel,
  output logic [NUM_LINES-1:0] mask,
  output logic [NUM_LINES-1:0] sw_set,
  output logic [NUM_LINES-1:0] rclr,
  output logic [NUM_LINES-1:0] fclr,
  output logic [NUM_LINES-1:0] rdata
);

  reg_sel_e             sel;
  logic                 rsel_en;
  logic                 fsel_en;
  logic                 mask_en;
  logic [NUM_LINES-1:0] rsel_q;
  logic [NUM_LINES-1:0] fsel_q;
  logic [NUM_LINES-1:0] mask_q;

  always_comb begin
    sel     = decode_ofs(addr);
    rsel_en = wen && (sel == SEL_RISE_SEL);
    fsel_en = wen && (sel == SEL_FALL_SEL);
    mask_en = wen && (sel == SEL_MASK);
    sw_set  = (wen && (sel == SEL_SW_TRIG))   ? wdata : '0;
    rclr    = (wen && (sel == SEL_RISE_PEND)) ? wdata : '0;
    fclr    = (wen && (sel == SEL_FALL_PEND)) ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsel_q <= '0;
    end else if (rsel_en) begin
      rsel_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fsel_q <= '0;
    end else if (fsel_en) begin
      fsel_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_RISE_SEL:  rdata = rsel_q;
      SEL_FALL_SEL:  rdata = fsel_q;
      SEL_RISE_PEND: rdata = rpend;
      SEL_FALL_PEND: rdata = fpend;
      SEL_RESERVED:  rdata = RSV_LINES;
      SEL_MASK:      rdata = mask_q;
      SEL_CAP:       rdata = CFG_LINES;
      default:       rdata = '0;
    endcase
  end

  assign rsel = rsel_q;
  assign fsel = fsel_q;
  assign mask = mask_q;

endmodule

// File: rtl/evt_pend.sv
module evt_pend #(
  parameter int unsigned          NUM_LINES = 32,
  parameter logic [NUM_LINES-1:0] CFG_LINES = '1
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] rise,
  input  logic [NUM_LINES-1:0] fall,
  input  logic [NUM_LINES-1:0] rsel,
  input  logic [NUM_LINES-1:0] fsel,
  input  logic [NUM_LINES-1:0] sw_set,
  input  logic [NUM_LINES-1:0] rclr,
  input  logic [NUM_LINES-1:0] fclr,
  output logic [NUM_LINES-1:0] rpend,
  output logic [NUM_LINES-1:0] fpend
);

  logic [NUM_LINES-1:0] rp_q;
  logic [NUM_LINES-1:0] rp_d;
  logic [NUM_LINES-1:0] fp_q;
  logic [NUM_LINES-1:0] fp_d;
  logic [NUM_LINES-1:0] r_hit;
  logic [NUM_LINES-1:0] f_hit;

  // A set term is ORed in after the clear, so a new edge beats a clear.
  always_comb begin
    r_hit = (rise & rsel) | sw_set;
    f_hit = fall & fsel;
    rp_d  = CFG_LINES & (r_hit | (rp_q & ~rclr));
    fp_d  = CFG_LINES & (f_hit | (fp_q & ~fclr));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q <= '0;
      fp_q <= '0;
    end else begin
      rp_q <= rp_d;
      fp_q <= fp_d;
    end
  end

  assign rpend = rp_q;
  assign fpend = fp_q;

endmodule

// File: rtl/evt_line_ctrl.sv
module evt_line_ctrl
  import evt_pkg::*;
#(
  parameter int unsigned          NUM_LINES   = 32,
  parameter int unsigned          SYNC_STAGES = 2,
  parameter logic [NUM_LINES-1:0] CFG_LINES   = 32'h3FFF_FFFF,
  parameter logic [NUM_LINES-1:0] RSV_LINES   = 32'h0000_0300
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] evt_in,
  input  logic [EVT_AW-1:0]    addr,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic                 wen,
  output logic [NUM_LINES-1:0] rdata,
  output logic [NUM_LINES-1:0] irq_out
);

  logic                 rst_ni;
  logic [NUM_LINES-1:0] lvl;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] fall;
  logic [NUM_LINES-1:0] rsel;
  logic [NUM_LINES-1:0] fsel;
  logic [NUM_LINES-1:0] mask;
  logic [NUM_LINES-1:0] sw_set;
  logic [NUM_LINES-1:0] rclr;
  logic [NUM_LINES-1:0] fclr;
  logic [NUM_LINES-1:0] rpend;
  logic [NUM_LINES-1:0] fpend;

  evt_rst_sync #(
    .STAGES (2)
  ) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  evt_in_sync #(
    .NUM_LINES   (NUM_LINES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .evt_in (evt_in),
    .lvl    (lvl),
    .rise   (rise),
    .fall   (fall)
  );

  evt_cfg_regs #(
    .NUM_LINES (NUM_LINES),
    .CFG_LINES (CFG_LINES),
    .RSV_LINES (RSV_LINES)
  ) u_regs (
    .clk    (clk),
    .rst_ni (rst_ni),
    .addr   (addr),
    .wdata  (wdata),
    .wen    (wen),
    .rpend  (rpend),
    .fpend  (fpend),
    .rsel   (rsel),
    .fsel   (fsel),
    .mask   (mask),
    .sw_set (sw_set),
    .rclr   (rclr),
    .fclr   (fclr),
    .rdata  (rdata)
  );

  evt_pend #(
    .NUM_LINES (NUM_LINES),
    .CFG_LINES (CFG_LINES)
  ) u_pend (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rise   (rise),
    .fall   (fall),
    .rsel   (rsel),
    .fsel   (fsel),
    .sw_set (sw_set),
    .rclr   (rclr),
    .fclr   (fclr),
    .rpend  (rpend),
    .fpend  (fpend)
  );

  // Configurable lines drive from their pending flags, direct lines from their level.
  assign irq_out = mask & ((CFG_LINES & (rpend | fpend)) | (~CFG_LINES & lvl));

endmodule

// File: rtl/evt_line_ctrl_chk.sv
module evt_line_ctrl_chk
  import evt_pkg::*;
#(
  parameter int unsigned          NL  = 32,
  parameter logic [NL-1:0]        CFG = '1
) (
  input logic              clk,
  input logic              rst_ni,
  input logic [EVT_AW-1:0] addr,
  input logic [NL-1:0]     wdata,
  input logic              wen,
  input logic [NL-1:0]     rdata,
  input logic [NL-1:0]     irq_out,
  input logic [NL-1:0]     rise,
  input logic [NL-1:0]     fall,
  input logic [NL-1:0]     rsel,
  input logic [NL-1:0]     fsel,
  input logic [NL-1:0]     rpend,
  input logic [NL-1:0]     fpend
);

  AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    (wen && addr == OFS_MASK && wdata == '0) |=> (irq_out == '0)); // R5

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    (wen && addr == OFS_RISE_PEND) |=> ((rpend & $past(wdata & ~(rise & rsel))) == '0)); // R3

  AST_SWT_SETS: assert property (@(posedge clk) disable iff (!rst_ni)
    (wen && addr == OFS_SW_TRIG) |=> ((rpend & $past(wdata & CFG)) == $past(wdata & CFG))); // R4

  AST_SWT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (addr == OFS_SW_TRIG) |-> (rdata == '0)); // R4

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (|(fall & fsel & CFG)) |=> ((fpend & $past(fall & fsel & CFG)) == $past(fall & fsel & CFG))); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (decode_ofs(addr) == SEL_NONE) |-> (rdata == '0)); // R9

endmodule

bind evt_line_ctrl evt_line_ctrl_chk #(
  .NL  (NUM_LINES),
  .CFG (CFG_LINES)
) chk_i (
  .clk     (clk),
  .rst_ni  (rst_ni),
  .addr    (addr),
  .wdata   (wdata),
  .wen     (wen),
  .rdata   (rdata),
  .irq_out (irq_out),
  .rise    (rise),
  .fall    (fall),
  .rsel    (rsel),
  .fsel    (fsel),
  .rpend   (rpend),
  .fpend   (fpend)
);

// File: tb/evt_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_line_ctrl_tb_top;

  localparam logic [31:0] CFG = 32'h3FFF_FFFF;
  localparam logic [31:0] RSV = 32'h0000_0300;
  localparam int unsigned MAX_CYC = 200000;

  logic        clk;
  logic        rst_n;
  logic [31:0] evt_in;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic        wen;
  logic [31:0] rdata;
  logic [31:0] irq_out;

  int n_chk;
  int n_err;
  bit done;
  bit live_chk;

  evt_line_ctrl #(
    .NUM_LINES   (32),
    .SYNC_STAGES (2),
    .CFG_LINES   (CFG),
    .RSV_LINES   (RSV)
  ) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_in  (evt_in),
    .addr    (addr),
    .wdata   (wdata),
    .wen     (wen),
    .rdata   (rdata),
    .irq_out (irq_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model of the requirements, updated on each rising edge.
  logic        m_r1, m_r2;
  logic [31:0] m_s1, m_s2, m_prev, m_rsel, m_fsel, m_mask, m_rp, m_fp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 <= 0; m_r2 <= 0;
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0;
      m_rsel <= 0; m_fsel <= 0; m_mask <= 0; m_rp <= 0; m_fp <= 0;
    end else begin
      m_r1 <= 1'b1;
      m_r2 <= m_r1;
      if (m_r2) begin
        logic [31:0] up, dn, sw, cr, cf;
        up = m_s2 & ~m_prev;
        dn = ~m_s2 & m_prev;
        sw = (wen && addr == 12'h008) ? wdata : 32'h0;
        cr = (wen && addr == 12'h00C) ? wdata : 32'h0;
        cf = (wen && addr == 12'h010) ? wdata : 32'h0;
        m_rp <= CFG & ((up & m_rsel) | sw | (m_rp & ~cr));
        m_fp <= CFG & ((dn & m_fsel) | (m_fp & ~cf));
        if (wen && addr == 12'h000) m_rsel <= wdata;
        if (wen && addr == 12'h004) m_fsel <= wdata;
        if (wen && addr == 12'h080) m_mask <= wdata;
        m_s1 <= evt_in;
        m_s2 <= m_s1;
        m_prev <= m_s2;
      end
    end
  end

  function automatic logic [31:0] exp_irq();
    return m_mask & ((CFG & (m_rp | m_fp)) | (~CFG & m_s2));
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    case (a)
      12'h000: return m_rsel;
      12'h004: return m_fsel;
      12'h00C: return m_rp;
      12'h010: return m_fp;
      12'h014: return RSV;
      12'h080: return m_mask;
      12'h3EC: return CFG;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %08h expected %08h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // Caller stands just after a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wen = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wen = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  // Per-cycle comparison of the interrupt outputs against the model.
  always @(negedge clk) begin
    #2;
    if (live_chk) chk("R5 irq_out vs model", irq_out, exp_irq());
  end

  initial begin
    #(20 * MAX_CYC);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    logic [11:0] alist [10];
    alist = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010,
              12'h014, 12'h080, 12'h3EC, 12'h018, 12'h7FC};
    void'($urandom(32'h00C0_FFEE));
    n_chk = 0; n_err = 0; done = 0; live_chk = 0;
    rst_n = 0; evt_in = 0; addr = 0; wdata = 0; wen = 0;
    step(3);
    rst_n = 1;
    step(4);
    live_chk = 1;

    // R1 reset state
    rd(12'h000, v); chk("R1 rise select", v, 0);
    rd(12'h004, v); chk("R1 fall select", v, 0);
    rd(12'h080, v); chk("R1 mask", v, 0);
    rd(12'h00C, v); chk("R1 rise pend", v, 0);
    rd(12'h010, v); chk("R1 fall pend", v, 0);
    chk("R1 irq_out", irq_out, 0);

    // R7 read-only words
    rd(12'h3EC, v); chk("R7 capability", v, CFG);
    rd(12'h014, v); chk("R7 reserved", v, RSV);
    wr(12'h3EC, 32'h0); wr(12'h014, 32'hFFFF_FFFF);
    rd(12'h3EC, v); chk("R7 capability after write", v, CFG);
    rd(12'h014, v); chk("R7 reserved after write", v, RSV);

    // R10 read-back
    wr(12'h000, 32'hA5A5_5A5A); rd(12'h000, v); chk("R10 rise select", v, 32'hA5A5_5A5A);
    wr(12'h004, 32'h0F0F_1234); rd(12'h004, v); chk("R10 fall select", v, 32'h0F0F_1234);

    // R9 unmapped offsets
    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h018, v); chk("R9 unmapped read", v, 0);
    rd(12'h000, v); chk("R9 rise select kept", v, 32'hA5A5_5A5A);
    rd(12'h004, v); chk("R9 fall select kept", v, 32'h0F0F_1234);
    rd(12'h080, v); chk("R9 mask kept", v, 0);

    // R2 edge selection: rise on 0,2; fall on 1,2; none on 3
    wr(12'h000, 32'h5); wr(12'h004, 32'h6); wr(12'h080, 32'hFFFF_FFFF);
    evt_in = 32'hF;
    step(2);
    rd(12'h00C, v); chk("R2 rise pend not before third edge", v, 0);
    step(1);
    rd(12'h00C, v); chk("R2 rise pend after rise", v, 32'h5);
    rd(12'h010, v); chk("R2 fall pend after rise", v, 0);
    chk("R5 irq after rise", irq_out, 32'h5);
    evt_in = 32'h0;
    step(3);
    rd(12'h010, v); chk("R2 fall pend after fall", v, 32'h6);
    rd(12'h00C, v); chk("R2 rise pend held", v, 32'h5);
    chk("R5 irq after fall", irq_out, 32'h7);

    // R3 write-one-to-clear
    wr(12'h00C, 32'h1); rd(12'h00C, v); chk("R3 clear one rise bit", v, 32'h4);
    wr(12'h010, 32'h0); rd(12'h010, v); chk("R3 zero write keeps", v, 32'h6);
    wr(12'h010, 32'h6); rd(12'h010, v); chk("R3 clear fall bits", v, 0);
    wr(12'h00C, 32'h4); rd(12'h00C, v); chk("R3 clear last rise bit", v, 0);

    // R4 / R6 software trigger, one configurable and one direct line
    wr(12'h008, 32'h8000_0001);
    rd(12'h00C, v); chk("R4 R6 software trigger", v, 32'h1);
    rd(12'h008, v); chk("R4 trigger reads zero", v, 0);
    chk("R6 direct line ignores trigger", irq_out & 32'h8000_0000, 0);

    // R5 mask gates output, pending kept
    wr(12'h080, 32'hFFFF_FFFE);
    chk("R5 masked output", irq_out & 32'h1, 0);
    rd(12'h00C, v); chk("R5 pending kept under mask", v, 32'h1);
    wr(12'h00C, 32'h1);

    // R6 direct line level passes after two edges
    evt_in = 32'h4000_0000;
    step(1); chk("R6 direct after one edge", irq_out & 32'h4000_0000, 0);
    step(1); chk("R6 direct after two edges", irq_out & 32'h4000_0000, 32'h4000_0000);
    rd(12'h00C, v); chk("R6 no pend on direct", v & 32'hC000_0000, 0);
    evt_in = 32'h0;
    step(3);

    // R8 edge and clear on the same clock edge
    evt_in = 32'h1;
    step(2);
    wr(12'h00C, 32'h1);
    rd(12'h00C, v); chk("R8 edge beats clear", v & 32'h1, 32'h1);
    wr(12'h00C, 32'h1);
    rd(12'h00C, v); chk("R8 later clear", v & 32'h1, 0);

    // Random phase against the model
    for (int c = 0; c < 4000; c++) begin
      logic [11:0] a;
      evt_in = evt_in ^ ($urandom & $urandom & $urandom);
      if (($urandom % 3) == 0) begin
        a = alist[$urandom % 10];
        addr = a; wdata = $urandom; wen = 1'b1;
      end else begin
        wen = 1'b0;
        addr = alist[$urandom % 10];
      end
      #1;
      chk("R10 random read vs model", rdata, exp_rd(addr));
      @(negedge clk);
    end
    wen = 1'b0;
    step(2);
    done = 1;
    live_chk = 0;
    finish_run();
  end

endmodule